// File: doc/BRIEF.md
# Store-Set Dependence Predictor

This block tells an out-of-order core which earlier store, if any, a newly fetched load or store should wait for. The prediction is learned from past memory-ordering violations. A memory instruction that has never been involved in a violation runs without constraint. Once the disambiguation logic reports that a load collided with a store, the two instructions are tied into a common store set. After that, each fetch of a member of the set is ordered behind the most recently fetched store of that set.

Two register tables hold the state. The first table is indexed by low bits of the instruction address and maps an instruction to a set number, with a valid flag. The second table is indexed by set number and records the instruction number of the youngest fetched store of that set. A fetched store returns the previous youngest store as its own dependence and then takes its place. A store that resolves its address or retires removes its number from the second table. A periodic clear input forgets all set memberships, so that stale pairings age out.

Top module: `store_set_predictor`

## Requirements
- R1: After reset every set membership and every last-store entry is invalid, and the prediction outputs are zero.
- R2: A fetched load whose table entry holds no valid set gets no set and no dependence.
- R3: A fetched load in a valid set whose last-store entry is valid reports that set and that store's instruction number, one cycle after the fetch.
- R4: A fetched store in a valid set reports the previous last store of the set as its dependence (if valid), and its own instruction number becomes the set's last store.
- R5: A fetched store with no valid set reports nothing and changes no last-store entry.
- R6: A resolve report invalidates every last-store entry that holds the reported instruction number, so that later loads of that set report no dependence.
- R7: When a store fetch writes a last-store entry in the same cycle as a resolve that would invalidate that entry, the write wins.
- R8: On a violation where neither instruction has a set, both receive the set number from an allocation counter that starts at 0 and counts up modulo the number of sets; the last-store entry of that set is invalidated.
- R9: On a violation where exactly one instruction has a set, the other instruction is given that set.
- R10: On a violation where both instructions have sets, both are given the smaller of the two set numbers.
- R11: The clear input invalidates every set membership; a violation reported in the same cycle is dropped. The allocation counter is not reset by a clear.
- R12: The table index is instruction-address bits [ALIGN_BITS+IDX_W-1:ALIGN_BITS]; addresses that agree in those bits share an entry, and the alignment bits are ignored.
- R13: A fetch sees the tables as they were before the updates of its own cycle; in a cycle with no fetch the prediction outputs are zero on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A memory instruction is fetched this cycle |
| fetch_is_store | input | 1 | The fetched instruction is a store (else a load) |
| fetch_pc | input | PC_W | Address of the fetched instruction |
| fetch_inum | input | INUM_W | Instruction number of the fetched instruction |
| resolve_valid | input | 1 | A store resolved its address or retired |
| resolve_inum | input | INUM_W | Instruction number of that store |
| viol_valid | input | 1 | An ordering violation is reported |
| viol_load_pc | input | PC_W | Address of the violating load |
| viol_store_pc | input | PC_W | Address of the store it collided with |
| clear_sets | input | 1 | Invalidate all set memberships |
| pred_set_valid | output | 1 | The previous cycle's fetch belongs to a set |
| pred_set_id | output | SID_W | Set number of that fetch |
| pred_dep_valid | output | 1 | The fetch must wait on a store |
| pred_dep_inum | output | INUM_W | Instruction number of that store |

## Verification
The contested cycle is a store fetch that writes a set's last-store entry while a resolve report names the store already held in that entry. The bench drives both in one cycle twice in a row, and checks both the dependence the fetched store receives (the old store) and the dependence a following load of the same set receives (the new store, not an empty entry). A second overlap, a violation or clear arriving alongside a load fetch, is provoked the same way and judged by comparing the load's prediction with the later one.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    // How a violation report updates the set-ID table
    typedef enum logic [1:0] {
        MRG_NEW      = 2'd0,  // neither side has a set: allocate one
        MRG_TO_STORE = 2'd1,  // load's set copied onto the store
        MRG_TO_LOAD  = 2'd2,  // store's set copied onto the load
        MRG_MIN      = 2'd3   // both have sets: keep the smaller
    } merge_e;

endpackage

// File: rtl/ssp_id_table.sv
module ssp_id_table #(
    parameter int IDX_W = 4,
    parameter int SID_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [IDX_W-1:0] rd0_idx_i,
    output logic             rd0_vld_o,
    output logic [SID_W-1:0] rd0_sid_o,
    input  logic [IDX_W-1:0] rd1_idx_i,
    output logic             rd1_vld_o,
    output logic [SID_W-1:0] rd1_sid_o,
    input  logic [IDX_W-1:0] rd2_idx_i,
    output logic             rd2_vld_o,
    output logic [SID_W-1:0] rd2_sid_o,
    input  logic             wr_a_en_i,
    input  logic [IDX_W-1:0] wr_a_idx_i,
    input  logic             wr_b_en_i,
    input  logic [IDX_W-1:0] wr_b_idx_i,
    input  logic [SID_W-1:0] wr_sid_i
);
    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][SID_W-1:0] sid;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (clr_i) begin
            tbl_d.vld = '0;
        end else begin
            if (wr_a_en_i) begin
                tbl_d.vld[wr_a_idx_i] = 1'b1;
                tbl_d.sid[wr_a_idx_i] = wr_sid_i;
            end
            if (wr_b_en_i) begin
                tbl_d.vld[wr_b_idx_i] = 1'b1;
                tbl_d.sid[wr_b_idx_i] = wr_sid_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign rd0_vld_o = tbl_q.vld[rd0_idx_i];
    assign rd0_sid_o = tbl_q.sid[rd0_idx_i];
    assign rd1_vld_o = tbl_q.vld[rd1_idx_i];
    assign rd1_sid_o = tbl_q.sid[rd1_idx_i];
    assign rd2_vld_o = tbl_q.vld[rd2_idx_i];
    assign rd2_sid_o = tbl_q.sid[rd2_idx_i];

endmodule

// File: rtl/ssp_last_store.sv
module ssp_last_store #(
    parameter int SET_IDS = 8,
    parameter int SID_W   = 3,
    parameter int INUM_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SID_W-1:0]  rd_sid_i,
    output logic              rd_vld_o,
    output logic [INUM_W-1:0] rd_inum_o,
    input  logic              wr_en_i,
    input  logic [SID_W-1:0]  wr_sid_i,
    input  logic [INUM_W-1:0] wr_inum_i,
    input  logic              kill_en_i,
    input  logic [SID_W-1:0]  kill_sid_i,
    input  logic              res_en_i,
    input  logic [INUM_W-1:0] res_inum_i
);
    typedef struct packed {
        logic [SET_IDS-1:0]             vld;
        logic [SET_IDS-1:0][INUM_W-1:0] inum;
    } lst_t;

    lst_t lst_d, lst_q;
    logic [SET_IDS-1:0] res_hit;
    logic [SET_IDS-1:0] kill_hit;
    logic [SET_IDS-1:0] wr_hit;

    // per-entry match logic, one comparator set per store set
    for (genvar e = 0; e < SET_IDS; e++) begin : g_entry
        assign res_hit[e]  = res_en_i && lst_q.vld[e] && (lst_q.inum[e] == res_inum_i);
        assign kill_hit[e] = kill_en_i && (kill_sid_i == SID_W'(e));
        assign wr_hit[e]   = wr_en_i && (wr_sid_i == SID_W'(e));
    end

    always_comb begin
        lst_d = lst_q;
        for (int e = 0; e < SET_IDS; e++) begin
            if (res_hit[e] || kill_hit[e]) lst_d.vld[e] = 1'b0;
            // a new store write overrides any invalidation of the same entry
            if (wr_hit[e]) begin
                lst_d.vld[e]  = 1'b1;
                lst_d.inum[e] = wr_inum_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lst_q <= '0;
        else        lst_q <= lst_d;
    end

    assign rd_vld_o  = lst_q.vld[rd_sid_i];
    assign rd_inum_o = lst_q.inum[rd_sid_i];

endmodule

// File: rtl/ssp_merge.sv
module ssp_merge
    import ssp_pkg::*;
#(
    parameter int SID_W = 3
) (
    input  logic             viol_i,
    input  logic             ld_vld_i,
    input  logic [SID_W-1:0] ld_sid_i,
    input  logic             st_vld_i,
    input  logic [SID_W-1:0] st_sid_i,
    input  logic [SID_W-1:0] alloc_sid_i,
    output logic             wr_ld_o,
    output logic             wr_st_o,
    output logic [SID_W-1:0] wr_sid_o,
    output logic             take_alloc_o
);
    merge_e mode;

    always_comb begin
        unique case ({ld_vld_i, st_vld_i})
            2'b00:   mode = MRG_NEW;
            2'b10:   mode = MRG_TO_STORE;
            2'b01:   mode = MRG_TO_LOAD;
            default: mode = MRG_MIN;
        endcase
    end

    always_comb begin
        wr_ld_o      = 1'b0;
        wr_st_o      = 1'b0;
        wr_sid_o     = alloc_sid_i;
        take_alloc_o = 1'b0;
        if (viol_i) begin
            unique case (mode)
                MRG_NEW: begin
                    wr_ld_o      = 1'b1;
                    wr_st_o      = 1'b1;
                    take_alloc_o = 1'b1;
                end
                MRG_TO_STORE: begin
                    wr_st_o  = 1'b1;
                    wr_sid_o = ld_sid_i;
                end
                MRG_TO_LOAD: begin
                    wr_ld_o  = 1'b1;
                    wr_sid_o = st_sid_i;
                end
                MRG_MIN: begin
                    wr_ld_o  = 1'b1;
                    wr_st_o  = 1'b1;
                    wr_sid_o = (ld_sid_i < st_sid_i) ? ld_sid_i : st_sid_i;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/store_set_predictor.sv
module store_set_predictor #(
    parameter int PC_W       = 16,
    parameter int ALIGN_BITS = 2,
    parameter int ID_ENTRIES = 16,
    parameter int SET_IDS    = 8,
    parameter int INUM_W     = 6,
    localparam int IDX_W     = $clog2(ID_ENTRIES),
    localparam int SID_W     = $clog2(SET_IDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic              fetch_is_store,
    input  logic [PC_W-1:0]   fetch_pc,
    input  logic [INUM_W-1:0] fetch_inum,
    input  logic              resolve_valid,
    input  logic [INUM_W-1:0] resolve_inum,
    input  logic              viol_valid,
    input  logic [PC_W-1:0]   viol_load_pc,
    input  logic [PC_W-1:0]   viol_store_pc,
    input  logic              clear_sets,
    output logic              pred_set_valid,
    output logic [SID_W-1:0]  pred_set_id,
    output logic              pred_dep_valid,
    output logic [INUM_W-1:0] pred_dep_inum
);
    typedef struct packed {
        logic              set_vld;
        logic [SID_W-1:0]  set_id;
        logic              dep_vld;
        logic [INUM_W-1:0] dep_inum;
        logic [SID_W-1:0]  alloc;
    } st_t;

    st_t st_d, st_q;

    logic [IDX_W-1:0]  f_idx, vl_idx, vs_idx;
    logic              f_vld, vl_vld, vs_vld;
    logic [SID_W-1:0]  f_sid, vl_sid, vs_sid;
    logic              lst_vld;
    logic [INUM_W-1:0] lst_inum;
    logic              viol_eff;
    logic              wr_ld, wr_st, take_alloc;
    logic [SID_W-1:0]  wr_sid;
    logic              st_write;

    assign f_idx  = fetch_pc[ALIGN_BITS +: IDX_W];
    assign vl_idx = viol_load_pc[ALIGN_BITS +: IDX_W];
    assign vs_idx = viol_store_pc[ALIGN_BITS +: IDX_W];

    assign viol_eff = viol_valid && !clear_sets;

    ssp_id_table #(.IDX_W(IDX_W), .SID_W(SID_W)) u_ids (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clear_sets),
        .rd0_idx_i  (f_idx),
        .rd0_vld_o  (f_vld),
        .rd0_sid_o  (f_sid),
        .rd1_idx_i  (vl_idx),
        .rd1_vld_o  (vl_vld),
        .rd1_sid_o  (vl_sid),
        .rd2_idx_i  (vs_idx),
        .rd2_vld_o  (vs_vld),
        .rd2_sid_o  (vs_sid),
        .wr_a_en_i  (wr_ld),
        .wr_a_idx_i (vl_idx),
        .wr_b_en_i  (wr_st),
        .wr_b_idx_i (vs_idx),
        .wr_sid_i   (wr_sid)
    );

    ssp_merge #(.SID_W(SID_W)) u_merge (
        .viol_i       (viol_eff),
        .ld_vld_i     (vl_vld),
        .ld_sid_i     (vl_sid),
        .st_vld_i     (vs_vld),
        .st_sid_i     (vs_sid),
        .alloc_sid_i  (st_q.alloc),
        .wr_ld_o      (wr_ld),
        .wr_st_o      (wr_st),
        .wr_sid_o     (wr_sid),
        .take_alloc_o (take_alloc)
    );

    assign st_write = fetch_valid && fetch_is_store && f_vld;

    ssp_last_store #(.SET_IDS(SET_IDS), .SID_W(SID_W), .INUM_W(INUM_W)) u_lst (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_sid_i   (f_sid),
        .rd_vld_o   (lst_vld),
        .rd_inum_o  (lst_inum),
        .wr_en_i    (st_write),
        .wr_sid_i   (f_sid),
        .wr_inum_i  (fetch_inum),
        .kill_en_i  (take_alloc),
        .kill_sid_i (st_q.alloc),
        .res_en_i   (resolve_valid),
        .res_inum_i (resolve_inum)
    );

    always_comb begin
        st_d          = st_q;
        st_d.set_vld  = fetch_valid && f_vld;
        st_d.set_id   = (fetch_valid && f_vld) ? f_sid : '0;
        st_d.dep_vld  = fetch_valid && f_vld && lst_vld;
        st_d.dep_inum = (fetch_valid && f_vld && lst_vld) ? lst_inum : '0;
        if (take_alloc) begin
            st_d.alloc = (st_q.alloc == SID_W'(SET_IDS - 1)) ? '0 : st_q.alloc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pred_set_valid = st_q.set_vld;
    assign pred_set_id    = st_q.set_id;
    assign pred_dep_valid = st_q.dep_vld;
    assign pred_dep_inum  = st_q.dep_inum;

endmodule

// File: rtl/ssp_checks.sv
module ssp_checks #(
    parameter int SID_W  = 3,
    parameter int INUM_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid,
    input logic              fetch_is_store,
    input logic              resolve_valid,
    input logic [INUM_W-1:0] resolve_inum,
    input logic              clear_sets,
    input logic              pred_set_valid,
    input logic [SID_W-1:0]  pred_set_id,
    input logic              pred_dep_valid,
    input logic [INUM_W-1:0] pred_dep_inum
);
    logic              clr_seen_q;
    logic              res_seen_q;
    logic [INUM_W-1:0] res_inum_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_seen_q <= 1'b0;
            res_seen_q <= 1'b0;
            res_inum_q <= '0;
        end else begin
            clr_seen_q <= clear_sets;
            res_seen_q <= resolve_valid && !fetch_valid;
            res_inum_q <= resolve_inum;
        end
    end

    // R13: no fetch, no prediction on the next cycle
    p_quiet_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> (!pred_set_valid && !pred_dep_valid));

    // R3: a dependence is only reported for a member of a set
    p_dep_needs_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pred_dep_valid |-> pred_set_valid);

    // R11: a fetch right after a clear finds no set
    p_clear_forgets_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_seen_q && fetch_valid) |=> !pred_set_valid);

    // R6: a load right after a resolve never waits on the resolved store
    p_resolved_gone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_seen_q && fetch_valid && !fetch_is_store)
            |=> !(pred_dep_valid && pred_dep_inum == $past(res_inum_q)));

    // R1: outputs are clear in the first cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!pred_set_valid && !pred_dep_valid && pred_set_id == '0));

endmodule

bind store_set_predictor ssp_checks #(.SID_W(SID_W), .INUM_W(INUM_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_valid    (fetch_valid),
    .fetch_is_store (fetch_is_store),
    .resolve_valid  (resolve_valid),
    .resolve_inum   (resolve_inum),
    .clear_sets     (clear_sets),
    .pred_set_valid (pred_set_valid),
    .pred_set_id    (pred_set_id),
    .pred_dep_valid (pred_dep_valid),
    .pred_dep_inum  (pred_dep_inum)
);

// File: tb/store_set_predictor_tb.sv
module store_set_predictor_tb;

    localparam logic [1:0] OP_LD  = 2'd0;
    localparam logic [1:0] OP_ST  = 2'd1;
    localparam logic [1:0] OP_VIO = 2'd2;
    localparam logic [1:0] OP_RES = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] a;     // fetch pc, violating load pc, or resolved inum
        logic [15:0] b;     // store inum or violating store pc
        logic        esv;
        logic [2:0]  esid;
        logic        edv;
        logic [5:0]  edin;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t TAB [NVEC] = '{
        '{OP_LD,  16'h0010, 16'h0000, 1'b0, 3'd0, 1'b0, 6'd0,  4'd2},  // R2 no set
        '{OP_ST,  16'h0020, 16'h0005, 1'b0, 3'd0, 1'b0, 6'd0,  4'd5},  // R5 store no set
        '{OP_VIO, 16'h0010, 16'h0020, 1'b0, 3'd0, 1'b0, 6'd0,  4'd8},  // R8 new set 0
        '{OP_LD,  16'h0010, 16'h0000, 1'b1, 3'd0, 1'b0, 6'd0,  4'd8},  // R8 load joined
        '{OP_ST,  16'h0020, 16'h0007, 1'b1, 3'd0, 1'b0, 6'd0,  4'd4},  // R4 first store
        '{OP_LD,  16'h0010, 16'h0000, 1'b1, 3'd0, 1'b1, 6'd7,  4'd3},  // R3 wait on 7
        '{OP_ST,  16'h0020, 16'h0009, 1'b1, 3'd0, 1'b1, 6'd7,  4'd4},  // R4 chain
        '{OP_VIO, 16'h0040, 16'h0030, 1'b0, 3'd0, 1'b0, 6'd0,  4'd8},  // R8 new set 1
        '{OP_VIO, 16'h0010, 16'h0030, 1'b0, 3'd0, 1'b0, 6'd0,  4'd10}, // R10 merge
        '{OP_ST,  16'h0030, 16'h000B, 1'b1, 3'd0, 1'b1, 6'd9,  4'd10}, // R10 took 0
        '{OP_LD,  16'h0040, 16'h0000, 1'b1, 3'd1, 1'b0, 6'd0,  4'd10}, // R10 load kept 1
        '{OP_VIO, 16'h0040, 16'h0054, 1'b0, 3'd0, 1'b0, 6'd0,  4'd9},  // R9 copy
        '{OP_ST,  16'h0054, 16'h000D, 1'b1, 3'd1, 1'b0, 6'd0,  4'd9},  // R9 store in 1
        '{OP_LD,  16'h0040, 16'h0000, 1'b1, 3'd1, 1'b1, 6'd13, 4'd9},  // R9
        '{OP_RES, 16'h000D, 16'h0000, 1'b0, 3'd0, 1'b0, 6'd0,  4'd6},  // R6 resolve
        '{OP_LD,  16'h0040, 16'h0000, 1'b1, 3'd1, 1'b0, 6'd0,  4'd6},  // R6 gone
        '{OP_LD,  16'h0410, 16'h0000, 1'b1, 3'd0, 1'b1, 6'd11, 4'd12}, // R12 alias
        '{OP_LD,  16'h0012, 16'h0000, 1'b1, 3'd0, 1'b1, 6'd11, 4'd12}  // R12 align bits
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic        fetch_is_store = 1'b0;
    logic [15:0] fetch_pc = '0;
    logic [5:0]  fetch_inum = '0;
    logic        resolve_valid = 1'b0;
    logic [5:0]  resolve_inum = '0;
    logic        viol_valid = 1'b0;
    logic [15:0] viol_load_pc = '0;
    logic [15:0] viol_store_pc = '0;
    logic        clear_sets = 1'b0;
    logic        pred_set_valid;
    logic [2:0]  pred_set_id;
    logic        pred_dep_valid;
    logic [5:0]  pred_dep_inum;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    store_set_predictor u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .fetch_valid    (fetch_valid),
        .fetch_is_store (fetch_is_store),
        .fetch_pc       (fetch_pc),
        .fetch_inum     (fetch_inum),
        .resolve_valid  (resolve_valid),
        .resolve_inum   (resolve_inum),
        .viol_valid     (viol_valid),
        .viol_load_pc   (viol_load_pc),
        .viol_store_pc  (viol_store_pc),
        .clear_sets     (clear_sets),
        .pred_set_valid (pred_set_valid),
        .pred_set_id    (pred_set_id),
        .pred_dep_valid (pred_dep_valid),
        .pred_dep_inum  (pred_dep_inum)
    );

    // one cycle of stimulus, driven at the falling edge; returns at the next falling edge
    task automatic cyc(input logic fv, input logic fst, input logic [15:0] pc,
                       input logic [5:0] inum, input logic vv, input logic [15:0] lpc,
                       input logic [15:0] spc, input logic rv, input logic [5:0] rin,
                       input logic clr);
        fetch_valid    = fv;
        fetch_is_store = fst;
        fetch_pc       = pc;
        fetch_inum     = inum;
        viol_valid     = vv;
        viol_load_pc   = lpc;
        viol_store_pc  = spc;
        resolve_valid  = rv;
        resolve_inum   = rin;
        clear_sets     = clr;
        @(posedge clk);
        @(negedge clk);
        fetch_valid   = 1'b0;
        viol_valid    = 1'b0;
        resolve_valid = 1'b0;
        clear_sets    = 1'b0;
    endtask

    task automatic expect_out(input int req, input logic esv, input logic [2:0] esid,
                              input logic edv, input logic [5:0] edin);
        checks++;
        if (pred_set_valid !== esv || pred_set_id !== esid ||
            pred_dep_valid !== edv || pred_dep_inum !== edin) begin
            errors++;
            $display("FAIL R%0d: got set %b/%0d dep %b/%0d, expected set %b/%0d dep %b/%0d",
                     req, pred_set_valid, pred_set_id, pred_dep_valid, pred_dep_inum,
                     esv, esid, edv, edin);
        end
    endtask

    task automatic ld(input logic [15:0] pc);
        cyc(1'b1, 1'b0, pc, 6'd0, 1'b0, 16'h0, 16'h0, 1'b0, 6'd0, 1'b0);
    endtask

    task automatic st(input logic [15:0] pc, input logic [5:0] inum);
        cyc(1'b1, 1'b1, pc, inum, 1'b0, 16'h0, 16'h0, 1'b0, 6'd0, 1'b0);
    endtask

    task automatic vio(input logic [15:0] lpc, input logic [15:0] spc);
        cyc(1'b0, 1'b0, 16'h0, 6'd0, 1'b1, lpc, spc, 1'b0, 6'd0, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, got %0d cycles, expected below 20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state visible at the outputs
        expect_out(1, 1'b0, 3'd0, 1'b0, 6'd0);
        ld(16'h0010);
        expect_out(1, 1'b0, 3'd0, 1'b0, 6'd0);

        for (int i = 0; i < NVEC; i++) begin
            case (TAB[i].op)
                OP_LD:  ld(TAB[i].a);
                OP_ST:  st(TAB[i].a, TAB[i].b[5:0]);
                OP_VIO: vio(TAB[i].a, TAB[i].b);
                default: cyc(1'b0, 1'b0, 16'h0, 6'd0, 1'b0, 16'h0, 16'h0,
                             1'b1, TAB[i].a[5:0], 1'b0);
            endcase
            expect_out(int'(TAB[i].req), TAB[i].esv, TAB[i].esid, TAB[i].edv, TAB[i].edin);
        end

        // R7: store write and resolve of the entry's old store in one cycle
        cyc(1'b1, 1'b1, 16'h0020, 6'd20, 1'b0, 16'h0, 16'h0, 1'b1, 6'd11, 1'b0);
        expect_out(7, 1'b1, 3'd0, 1'b1, 6'd11);
        ld(16'h0010);
        expect_out(7, 1'b1, 3'd0, 1'b1, 6'd20);
        cyc(1'b1, 1'b1, 16'h0020, 6'd22, 1'b0, 16'h0, 16'h0, 1'b1, 6'd20, 1'b0);
        expect_out(7, 1'b1, 3'd0, 1'b1, 6'd20);
        ld(16'h0010);
        expect_out(7, 1'b1, 3'd0, 1'b1, 6'd22);

        // R13: a load fetched with a violation naming it sees the old table
        cyc(1'b1, 1'b0, 16'h0018, 6'd0, 1'b1, 16'h0018, 16'h001C, 1'b0, 6'd0, 1'b0);
        expect_out(13, 1'b0, 3'd0, 1'b0, 6'd0);
        ld(16'h0018);
        expect_out(8, 1'b1, 3'd2, 1'b0, 6'd0);   // R8 counter advanced to 2

        // R11: clear with a simultaneous violation
        cyc(1'b0, 1'b0, 16'h0, 6'd0, 1'b1, 16'h0008, 16'h000C, 1'b0, 6'd0, 1'b1);
        expect_out(13, 1'b0, 3'd0, 1'b0, 6'd0);
        ld(16'h0010);
        expect_out(11, 1'b0, 3'd0, 1'b0, 6'd0);
        ld(16'h000C);
        expect_out(11, 1'b0, 3'd0, 1'b0, 6'd0);

        // R8: counter keeps its value over the clear and wraps to 0
        vio(16'h0000, 16'h0004);
        vio(16'h0008, 16'h000C);
        vio(16'h0010, 16'h0014);
        vio(16'h0018, 16'h001C);
        vio(16'h0020, 16'h0024);
        ld(16'h0024);
        expect_out(8, 1'b1, 3'd7, 1'b0, 6'd0);
        vio(16'h0028, 16'h002C);
        ld(16'h002C);
        expect_out(8, 1'b1, 3'd0, 1'b0, 6'd0);   // old last store 22 dropped
        st(16'h0028, 6'd30);
        expect_out(4, 1'b1, 3'd0, 1'b0, 6'd0);
        ld(16'h002C);
        expect_out(3, 1'b1, 3'd0, 1'b1, 6'd30);

        // R1: reset in mid-run forgets everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        ld(16'h002C);
        expect_out(1, 1'b0, 3'd0, 1'b0, 6'd0);

        finish_run();
    end

endmodule